// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog counter that lives behind a small synchronous register port (byte address, write strobe, write word, combinational read word). A 16-bit down counter is decremented once per slow tick. The tick is derived from the system clock by two stages in series: an 8-bit programmable prescaler that divides by its setting plus one, followed by a fixed divider chosen from four powers of two. When the counter sits at zero and a tick arrives, the timer has expired. It reloads itself from a separate reload register and, depending on two control bits, pulses an interrupt output, a reset request output, both, or neither.

Software keeps the system alive by writing a fresh value into the counter register before it runs out. Clearing the run bit freezes the counter and parks both divider stages at zero. Software can therefore stop the timer, and later restore it by writing the reload, counter and control registers again.

Top module: `wdog_timer`

## Requirements
- R1: After a synchronous reset, control reads 0x00008021 (prescaler 0x80, divide-by-16, run and reset request enabled, interrupt disabled), reload and counter both read 0x00008000, and both outputs are low.
- R2: The control register is at byte offset 0x00. Bit 0 is the reset-request enable, bit 2 the interrupt enable, bits 4:3 the divider select and bit 5 run. Bits 15:8 hold the prescaler. All other bits read zero. Reload (offset 0x04) and counter (offset 0x08) read their 16-bit value zero-extended.
- R3: A read of any offset other than 0x00, 0x04 and 0x08 returns zero, and a write there changes no register.
- R4: A write to the counter register loads the low 16 bits into the counter at that clock edge. It takes precedence over a tick in the same cycle, and it is the keep-alive action.
- R5: A write to the reload register does not alter the counter value.
- R6: With run set, ticks occur every (P+1)·D clocks, where P is the prescaler and D is 16, 32, 64 or 128 for select codes 0, 1, 2 and 3.
- R7: While run is clear, both divider stages are held at zero. The first tick after run is set therefore changes the counter exactly (P+1)·D clocks after the enabling write edge.
- R8: While run is clear, the counter keeps its value except when software writes it.
- R9: On each tick, a non-zero counter decrements by one, and a zero counter reloads from the reload register (expiry).
- R10: On expiry with bit 2 set, the interrupt output is high for exactly the one cycle after the expiry edge. With bit 2 clear, it stays low.
- R11: On expiry with bit 0 set, the reset request output is high for exactly the one cycle after the expiry edge. With bit 0 clear, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 32 | Write word |
| rd_data | output | 32 | Read word for `addr`, combinational |
| expire_irq | output | 1 | One-cycle interrupt pulse on expiry |
| expire_rst_req | output | 1 | One-cycle reset request pulse on expiry |

## Verification
The assertions rely on the shortest possible tick period being sixteen clocks. Because of that, two expiries can never fall on adjacent cycles, and a freshly started divider cannot tick in the cycle after run rises. They also assume that a write is held for a single clock and that the address is stable around the edge. The stimulus drives every write as a one-cycle strobe set up half a period ahead of the edge. It changes the control register only while the counter is stopped or at known phases, so each expected counter value can be derived from the (P+1)·D period alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_W    = 32;
    localparam int ADDR_W   = 8;
    localparam int CNT_W    = 16;
    localparam int PRE_W    = 8;
    localparam int DIVCNT_W = 7;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h08;

    localparam logic [CNT_W-1:0] CNT_RST_VAL = 16'h8000;

    typedef enum logic [1:0] {
        DIV_16  = 2'd0,
        DIV_32  = 2'd1,
        DIV_64  = 2'd2,
        DIV_128 = 2'd3
    } div_sel_e;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic             run;
        div_sel_e         div;
        logic             irq_en;
        logic             rst_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST_VAL = '{presc: 8'h80, run: 1'b1, div: DIV_16,
                                       irq_en: 1'b0, rst_en: 1'b1};

    // Terminal count of the second divider stage for a given select code
    function automatic logic [DIVCNT_W-1:0] div_last(div_sel_e sel);
        logic [DIVCNT_W-1:0] r;
        case (sel)
            DIV_16:  r = 7'd15;
            DIV_32:  r = 7'd31;
            DIV_64:  r = 7'd63;
            default: r = 7'd127;
        endcase
        return r;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(ctrl_t c);
        logic [REG_W-1:0] w;
        w        = '0;
        w[15:8]  = c.presc;
        w[5]     = c.run;
        w[4:3]   = c.div;
        w[2]     = c.irq_en;
        w[0]     = c.rst_en;
        return w;
    endfunction

    function automatic ctrl_t ctrl_from_word(logic [REG_W-1:0] w);
        ctrl_t c;
        c.presc  = w[15:8];
        c.run    = w[5];
        c.div    = div_sel_e'(w[4:3]);
        c.irq_en = w[2];
        c.rst_en = w[0];
        return c;
    endfunction

endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = REG_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [CW-1:0] cnt_val,
    output ctrl_t         ctrl_o,
    output logic [CW-1:0] reload_o,
    output logic          cnt_wr_o,
    output logic [DW-1:0] rd_data
);

    logic hit_ctrl, hit_reload, hit_count, hit_any;

    assign hit_ctrl   = (addr == AW'(OFS_CTRL));
    assign hit_reload = (addr == AW'(OFS_RELOAD));
    assign hit_count  = (addr == AW'(OFS_COUNT));
    assign hit_any    = hit_ctrl | hit_reload | hit_count;
    assign cnt_wr_o   = wr_en & hit_count;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o   <= CTRL_RST_VAL;
            reload_o <= CNT_RST_VAL;
        end else begin
            if (wr_en && hit_ctrl)   ctrl_o   <= ctrl_from_word(wr_data);
            if (wr_en && hit_reload) reload_o <= wr_data[CW-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (hit_ctrl)        rd_data = ctrl_to_word(ctrl_o);
        else if (hit_reload) rd_data = DW'(reload_o);
        else if (hit_count)  rd_data = DW'(cnt_val);
    end

    // R3
    unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit_any) |=> (ctrl_o == $past(ctrl_o) && reload_o == $past(reload_o)));

    // R3
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_any |-> rd_data == '0);

endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
    import wdt_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int DCW = DIVCNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [PW-1:0] presc,
    input  div_sel_e      div_sel,
    output logic          tick_o
);

    logic [PW-1:0]  pre_cnt;
    logic [DCW-1:0] div_cnt;
    logic           pre_wrap, div_wrap;

    // >= keeps a shrinking setting from sending a stage around its full range
    assign pre_wrap = (pre_cnt >= presc);
    assign div_wrap = (div_cnt >= DCW'(div_last(div_sel)));
    assign tick_o   = run & pre_wrap & div_wrap;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    // R7
    no_tick_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> !tick_o);

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
    import wdt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter logic [CW-1:0] RST_VAL = CNT_RST_VAL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] reload_val,
    input  logic          irq_en,
    input  logic          rst_en,
    output logic [CW-1:0] cnt_o,
    output logic          irq_o,
    output logic          rst_req_o
);

    logic at_zero, expire;

    assign at_zero = (cnt_o == '0);
    assign expire  = tick & ~load & at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o     <= RST_VAL;
            irq_o     <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            if (load)         cnt_o <= load_val;
            else if (tick)    cnt_o <= at_zero ? reload_val : cnt_o - 1'b1;
            irq_o     <= expire & irq_en;
            rst_req_o <= expire & rst_en;
        end
    end

    // R4
    keepalive_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_o == $past(load_val));

    // R9
    decrement_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);

    // R9
    expiry_reload_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> cnt_o == $past(reload_val));

    // R10
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(irq_en));

    // R11
    rst_req_gated_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> ($past(rst_en) && !$past(rst_req_o)));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = REG_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          expire_irq,
    output logic          expire_rst_req
);

    ctrl_t         ctrl;
    logic [CW-1:0] reload_val;
    logic [CW-1:0] cnt_val;
    logic          cnt_wr;
    logic          tick;

    wdt_regfile #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cnt_val  (cnt_val),
        .ctrl_o   (ctrl),
        .reload_o (reload_val),
        .cnt_wr_o (cnt_wr),
        .rd_data  (rd_data)
    );

    wdt_tick_gen #(.PW(PRE_W), .DCW(DIVCNT_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .presc   (ctrl.presc),
        .div_sel (ctrl.div),
        .tick_o  (tick)
    );

    wdt_down_counter #(.CW(CW), .RST_VAL(CNT_RST_VAL)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .load       (cnt_wr),
        .load_val   (wr_data[CW-1:0]),
        .reload_val (reload_val),
        .irq_en     (ctrl.irq_en),
        .rst_en     (ctrl.rst_en),
        .cnt_o      (cnt_val),
        .irq_o      (expire_irq),
        .rst_req_o  (expire_rst_req)
    );

    // R8
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !cnt_wr) |=> cnt_val == $past(cnt_val));

    // R5
    reload_write_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(OFS_RELOAD) && !tick) |=> cnt_val == $past(cnt_val));

endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        expire_irq, expire_rst_req;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    wdog_timer u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .expire_irq(expire_irq), .expire_rst_req(expire_rst_req)
    );

    // {address, write value, expected readback}
    localparam logic [95:0] VEC [0:5] = '{
        {32'h00, 32'hFFFF_FFDF, 32'h0000_FF1D},   // R2 all fields, run clear
        {32'h04, 32'hFFFF_1234, 32'h0000_1234},   // R2 reload
        {32'h08, 32'hABCD_5678, 32'h0000_5678},   // R4 counter load
        {32'h0C, 32'hFFFF_FFFF, 32'h0000_0000},   // R3 unmapped
        {32'h04, 32'h0000_0000, 32'h0000_0000},   // R5 reload cleared
        {32'h00, 32'h0000_0A14, 32'h0000_0A14}    // R2 mixed fields
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, held;
        bit seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 ctrl", 8'h00, 32'h0000_8021);
        rd_chk("R1 reload", 8'h04, 32'h0000_8000);
        rd_chk("R1 counter", 8'h08, 32'h0000_8000);
        check("R1 outputs", {30'd0, expire_irq, expire_rst_req}, 32'd0);

        // stop first so the table runs against a frozen counter
        wr(8'h00, 32'h0);
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd_chk("R2/R3/R4 table", VEC[i][71:64], VEC[i][31:0]);
        end
        rd_chk("R5 counter after reload writes", 8'h08, 32'h0000_5678);
        rd_chk("R3 ctrl after unmapped write", 8'h00, 32'h0000_0A14);
        wr(8'h10, 32'hFFFF_FFFF);
        rd_chk("R3 unmapped read", 8'hFC, 32'h0);
        rd_chk("R3 ctrl kept", 8'h00, 32'h0000_0A14);
        rd_chk("R3 reload kept", 8'h04, 32'h0);

        // R7/R9/R10 decrement timing and interrupt-only expiry
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h3);
        wr(8'h08, 32'h2);
        wr(8'h00, 32'h24);
        step(15); rd_chk("R7 before first tick", 8'h08, 32'h2);
        step(1);  rd_chk("R7 first tick", 8'h08, 32'h1);
        step(16); rd_chk("R9 second tick", 8'h08, 32'h0);
        step(15); check("R10 no early irq", {31'd0, expire_irq}, 32'd0);
        step(1);
        rd_chk("R9 reload on expiry", 8'h08, 32'h3);
        check("R10 irq pulse", {31'd0, expire_irq}, 32'd1);
        check("R11 rst_req off", {31'd0, expire_rst_req}, 32'd0);
        step(1);  check("R10 irq single cycle", {31'd0, expire_irq}, 32'd0);

        // R6 divider select sweep, prescaler 0
        for (int s = 0; s < 4; s++) begin
            int d;
            d = 16 << s;
            wr(8'h00, 32'h0);
            wr(8'h08, 32'd10);
            wr(8'h00, 32'h20 | (s << 3));
            step(d - 1); rd_chk("R6 select hold", 8'h08, 32'd10);
            step(1);     rd_chk("R6 select tick", 8'h08, 32'd9);
        end

        // R6 prescaler 2 with divide-by-32 (96 clocks)
        wr(8'h00, 32'h0);
        wr(8'h08, 32'd5);
        wr(8'h00, 32'h229);
        step(95); rd_chk("R6 prescaler hold", 8'h08, 32'd5);
        step(1);  rd_chk("R6 prescaler tick", 8'h08, 32'd4);

        // R8 stop holds, resume continues
        wr(8'h00, 32'h0);
        wr(8'h08, 32'd50);
        wr(8'h00, 32'h20);
        step(40);
        wr(8'h00, 32'h0);
        rd(8'h08, held);
        check("R8 value at stop", held, 32'd48);
        step(100);
        rd_chk("R8 held while stopped", 8'h08, held);
        wr(8'h00, 32'h20);
        step(15); rd_chk("R7 resume full period", 8'h08, held);
        step(1);  rd_chk("R8 resume decrement", 8'h08, held - 1);

        // R11 reset-request-only expiry
        wr(8'h00, 32'h0);
        wr(8'h04, 32'd7);
        wr(8'h08, 32'd0);
        wr(8'h00, 32'h21);
        step(15); check("R11 no early rst_req", {31'd0, expire_rst_req}, 32'd0);
        step(1);
        check("R11 rst_req pulse", {30'd0, expire_irq, expire_rst_req}, 32'd1);
        rd_chk("R9 reload 7", 8'h08, 32'd7);
        step(1);  check("R11 rst_req single cycle", {31'd0, expire_rst_req}, 32'd0);

        // R10/R11 both enabled
        wr(8'h00, 32'h0);
        wr(8'h08, 32'd0);
        wr(8'h00, 32'h25);
        step(16); check("R10 R11 both pulse", {30'd0, expire_irq, expire_rst_req}, 32'd3);

        // R10/R11 neither enabled: reload still happens, outputs stay low
        wr(8'h00, 32'h0);
        wr(8'h08, 32'd0);
        wr(8'h00, 32'h20);
        seen = 1'b0;
        for (int c = 0; c < 17; c++) begin
            step(1);
            if (expire_irq || expire_rst_req) seen = 1'b1;
        end
        check("R10 R11 masked", {31'd0, seen}, 32'd0);
        rd_chk("R9 masked reload", 8'h08, 32'd7);

        // R4 keep-alive prevents expiry, then expiry once it stops
        wr(8'h00, 32'h0);
        wr(8'h08, 32'd1);
        wr(8'h00, 32'h25);
        seen = 1'b0;
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 10; c++) begin
                step(1);
                if (expire_irq || expire_rst_req) seen = 1'b1;
            end
            wr(8'h08, 32'd1);
        end
        check("R4 keep-alive no expiry", {31'd0, seen}, 32'd0);
        seen = 1'b0;
        for (int c = 0; c < 40; c++) begin
            step(1);
            if (expire_rst_req) seen = 1'b1;
        end
        check("R4 expiry after keep-alive stops", {31'd0, seen}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule